// File: doc/BRIEF.md
# Sound Generator Test Register Port

This block sits at the CPU side of a five-channel sound generator and handles a 32-byte peripheral window. In normal operation it returns the two controller-port input bytes at their offsets and separates the external data bus only on reads of the channel-status offset. When the test-enable input is high it exposes three test registers, and the controller ports go out of view.

Reads of the test registers return the momentary DAC level of each channel, packed two channels to a byte for the four-bit channels. The delta-modulation level has a byte of its own. A write to the last test register loads a step value into the triangle sequencer with a one-cycle strobe. The same write sets or clears a freeze bit. While the freeze bit is set, the pulse and noise channels output their volume without gating, and the triangle and delta-modulation channels stop advancing.

While test mode is on, every read in the window separates the external bus. The channel logic itself is outside this block. It supplies the DAC levels and uses the freeze and load outputs.

Top module: `snd_test_port`

## Requirements
- R1: After reset, freeze_o, seq_load_o and seq_step_o are all zero.
- R2: With test mode on, a read of offset 0x18 returns the second pulse DAC level in bits 7:4 and the first pulse DAC level in bits 3:0.
- R3: With test mode on, a read of offset 0x19 returns the noise DAC level in bits 7:4 and the triangle DAC level in bits 3:0.
- R4: With test mode on, a read of offset 0x1A returns the 7-bit delta-modulation DAC level in bits 6:0, and bit 7 reads 0.
- R5: With test mode on, a write to offset 0x1A raises seq_load_o for the cycle after the write clock edge, with seq_step_o equal to write bits 4:0. Bits 6:5 have no effect, seq_step_o holds its value between loads, and writes to other offsets raise no strobe.
- R6: freeze_o takes write bit 7 of each test-mode write to 0x1A and holds it until the next such write. It reads 0 at once when test mode drops, and the stored bit clears, so freeze_o is 0 when test mode returns.
- R7: With test mode on, any read in the window (offsets 0x00 to 0x1F) asserts bus_cut_o and returns 0 on rdata_o outside 0x18 to 0x1A, so the controller bytes at 0x16 and 0x17 are not seen.
- R8: With test mode off, reads of 0x16 and 0x17 return pad0_i and pad1_i, and bus_cut_o is asserted only for a read of offset 0x15.
- R9: With test mode off, offsets 0x18 to 0x1A do not decode: reads return 0, and a write to 0x1A changes neither seq_load_o, seq_step_o nor freeze_o.
- R10: rdata_o is 0 and bus_cut_o is 0 whenever rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_en_i | input | 1 | Test mode enable |
| addr_i | input | 5 | Offset within the peripheral window |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pulse_a_dac_i | input | 4 | First pulse channel DAC level |
| pulse_b_dac_i | input | 4 | Second pulse channel DAC level |
| tri_dac_i | input | 4 | Triangle channel DAC level |
| noise_dac_i | input | 4 | Noise channel DAC level |
| dmc_dac_i | input | 7 | Delta-modulation DAC level |
| pad0_i | input | 8 | First controller-port read byte |
| pad1_i | input | 8 | Second controller-port read byte |
| freeze_o | output | 1 | Channel freeze |
| seq_load_o | output | 1 | Triangle sequencer load strobe |
| seq_step_o | output | 5 | Triangle sequencer step value |
| bus_cut_o | output | 1 | External data bus disconnect |

## Verification
The read path is driven with DAC levels that are asymmetric between the high and low nibble, so a nibble swap or a wrong channel pairing shows up. All-ones and all-zeros levels are also used, to expose masking errors. Controller bytes are distinct patterns and are read in both modes. This separates a port that hides the pads in test mode from one that passes them through, and shows which offset raises the disconnect flag in each mode. Sequencer writes use values with bits 6:5 set and bit 7 both set and clear. Writes with test mode off and writes to neighbouring offsets show that only a decoded test write reaches the load strobe or the freeze bit.

// File: rtl/snd_test_pkg.sv
package snd_test_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned VOL_W  = 4;
  localparam int unsigned DMC_W  = 7;
  localparam int unsigned STEP_W = 5;
  localparam int unsigned FRZ_BIT = 7;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h15;
  localparam logic [ADDR_W-1:0] OFS_PAD0   = 5'h16;
  localparam logic [ADDR_W-1:0] OFS_PAD1   = 5'h17;
  localparam logic [ADDR_W-1:0] OFS_SQR    = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_TN     = 5'h19;
  localparam logic [ADDR_W-1:0] OFS_DMC    = 5'h1A;

  typedef struct packed {
    logic status;
    logic pad0;
    logic pad1;
    logic sqr;
    logic tn;
    logic dmc;
  } sel_t;
endpackage

// File: rtl/snd_test_decode.sv
module snd_test_decode
  import snd_test_pkg::*;
(
  input  logic              test_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              sel_o
);
  always_comb begin
    sel_o        = '0;
    sel_o.status = (addr_i == OFS_STATUS);
    sel_o.pad0   = !test_en_i && (addr_i == OFS_PAD0);
    sel_o.pad1   = !test_en_i && (addr_i == OFS_PAD1);
    sel_o.sqr    = test_en_i && (addr_i == OFS_SQR);
    sel_o.tn     = test_en_i && (addr_i == OFS_TN);
    sel_o.dmc    = test_en_i && (addr_i == OFS_DMC);
  end
endmodule

// File: rtl/snd_test_rdmux.sv
module snd_test_rdmux
  import snd_test_pkg::*;
(
  input  logic              test_en_i,
  input  logic              rd_i,
  input  sel_t              sel_i,
  input  logic [VOL_W-1:0]  pulse_a_dac_i,
  input  logic [VOL_W-1:0]  pulse_b_dac_i,
  input  logic [VOL_W-1:0]  tri_dac_i,
  input  logic [VOL_W-1:0]  noise_dac_i,
  input  logic [DMC_W-1:0]  dmc_dac_i,
  input  logic [DATA_W-1:0] pad0_i,
  input  logic [DATA_W-1:0] pad1_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_cut_o
);
  localparam int unsigned DMC_PAD = DATA_W - DMC_W;

  logic [DATA_W-1:0] sqr_byte, tn_byte, dmc_byte;

  assign sqr_byte = {pulse_b_dac_i, pulse_a_dac_i};
  assign tn_byte  = {noise_dac_i, tri_dac_i};
  assign dmc_byte = {{DMC_PAD{1'b0}}, dmc_dac_i};

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (1'b1)
        sel_i.sqr:  rdata_o = sqr_byte;
        sel_i.tn:   rdata_o = tn_byte;
        sel_i.dmc:  rdata_o = dmc_byte;
        sel_i.pad0: rdata_o = pad0_i;
        sel_i.pad1: rdata_o = pad1_i;
        default:    rdata_o = '0;
      endcase
    end
  end

  // test mode isolates the whole window, otherwise only the status offset
  assign bus_cut_o = rd_i && (test_en_i || sel_i.status);
endmodule

// File: rtl/snd_test_ctrl.sv
module snd_test_ctrl
  import snd_test_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  input  logic              wr_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              freeze_o,
  output logic              seq_load_o,
  output logic [STEP_W-1:0] seq_step_o
);
  logic load_en;
  logic freeze_q;

  assign load_en = wr_i && hit_i && test_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freeze_q   <= 1'b0;
      seq_load_o <= 1'b0;
      seq_step_o <= '0;
    end else begin
      seq_load_o <= load_en;
      if (load_en) seq_step_o <= wdata_i[STEP_W-1:0];
      if (!test_en_i)   freeze_q <= 1'b0;
      else if (load_en) freeze_q <= wdata_i[FRZ_BIT];
    end
  end

  assign freeze_o = freeze_q && test_en_i;
endmodule

// File: rtl/snd_test_port.sv
module snd_test_port
  import snd_test_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [VOL_W-1:0]  pulse_a_dac_i,
  input  logic [VOL_W-1:0]  pulse_b_dac_i,
  input  logic [VOL_W-1:0]  tri_dac_i,
  input  logic [VOL_W-1:0]  noise_dac_i,
  input  logic [DMC_W-1:0]  dmc_dac_i,
  input  logic [DATA_W-1:0] pad0_i,
  input  logic [DATA_W-1:0] pad1_i,
  output logic              freeze_o,
  output logic              seq_load_o,
  output logic [STEP_W-1:0] seq_step_o,
  output logic              bus_cut_o
);
  sel_t sel;

  snd_test_decode u_decode (
    .test_en_i (test_en_i),
    .addr_i    (addr_i),
    .sel_o     (sel)
  );

  snd_test_rdmux u_rdmux (
    .test_en_i     (test_en_i),
    .rd_i          (rd_i),
    .sel_i         (sel),
    .pulse_a_dac_i (pulse_a_dac_i),
    .pulse_b_dac_i (pulse_b_dac_i),
    .tri_dac_i     (tri_dac_i),
    .noise_dac_i   (noise_dac_i),
    .dmc_dac_i     (dmc_dac_i),
    .pad0_i        (pad0_i),
    .pad1_i        (pad1_i),
    .rdata_o       (rdata_o),
    .bus_cut_o     (bus_cut_o)
  );

  snd_test_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .test_en_i  (test_en_i),
    .wr_i       (wr_i),
    .hit_i      (sel.dmc),
    .wdata_i    (wdata_i),
    .freeze_o   (freeze_o),
    .seq_load_o (seq_load_o),
    .seq_step_o (seq_step_o)
  );
endmodule

// File: rtl/snd_test_chk.sv
module snd_test_chk
  import snd_test_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              test_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              freeze_o,
  input logic              seq_load_o,
  input logic [STEP_W-1:0] seq_step_o,
  input logic              bus_cut_o
);
  logic tst_wr;
  assign tst_wr = test_en_i && wr_i && (addr_i == OFS_DMC);

  AST_LOAD_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst_wr |=> seq_load_o && (seq_step_o == $past(wdata_i[STEP_W-1:0]))); // R5

  AST_LOAD_ONLY_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tst_wr |=> !seq_load_o); // R9

  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tst_wr |=> $stable(seq_step_o)); // R5

  AST_FREEZE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |-> !freeze_o); // R6

  AST_CUT_IN_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && rd_i) |-> bus_cut_o); // R7

  AST_CUT_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_en_i && rd_i && addr_i != OFS_STATUS) |-> !bus_cut_o); // R8

  AST_DMC_MSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && rd_i && addr_i == OFS_DMC) |-> !rdata_o[DATA_W-1]); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0) && !bus_cut_o); // R10
endmodule

bind snd_test_port snd_test_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .test_en_i  (test_en_i),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .freeze_o   (freeze_o),
  .seq_load_o (seq_load_o),
  .seq_step_o (seq_step_o),
  .bus_cut_o  (bus_cut_o)
);

// File: tb/sim_snd_test_port.sv
module sim_snd_test_port;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       test_en_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] pulse_a_dac_i = '0, pulse_b_dac_i = '0, tri_dac_i = '0, noise_dac_i = '0;
  logic [6:0] dmc_dac_i = '0;
  logic [7:0] pad0_i = '0, pad1_i = '0;
  logic       freeze_o, seq_load_o, bus_cut_o;
  logic [4:0] seq_step_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  snd_test_port u0 (.*);

  typedef struct packed {
    logic       test;
    logic       rd;
    logic [4:0] addr;
    logic [3:0] pa, pb, tr, nz;
    logic [6:0] dmc;
    logic [7:0] p0, p1;
    logic [7:0] exp_data;
    logic       exp_cut;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,5'h18,4'h3,4'hA,4'h0,4'h0,7'h00,8'h00,8'h00,8'hA3,1'b1,4'd2},  // R2
    '{1'b1,1'b1,5'h18,4'hF,4'h0,4'h0,4'h0,7'h00,8'h00,8'h00,8'h0F,1'b1,4'd2},  // R2
    '{1'b1,1'b1,5'h19,4'h0,4'h0,4'h5,4'hC,7'h00,8'h00,8'h00,8'hC5,1'b1,4'd3},  // R3
    '{1'b1,1'b1,5'h19,4'h0,4'h0,4'hF,4'h0,7'h00,8'h00,8'h00,8'h0F,1'b1,4'd3},  // R3
    '{1'b1,1'b1,5'h1A,4'hF,4'hF,4'hF,4'hF,7'h7F,8'h00,8'h00,8'h7F,1'b1,4'd4},  // R4
    '{1'b1,1'b1,5'h1A,4'h0,4'h0,4'h0,4'h0,7'h2A,8'h00,8'h00,8'h2A,1'b1,4'd4},  // R4
    '{1'b1,1'b1,5'h16,4'h0,4'h0,4'h0,4'h0,7'h00,8'h5A,8'hC3,8'h00,1'b1,4'd7},  // R7
    '{1'b1,1'b1,5'h17,4'h0,4'h0,4'h0,4'h0,7'h00,8'h5A,8'hC3,8'h00,1'b1,4'd7},  // R7
    '{1'b1,1'b1,5'h00,4'h0,4'h0,4'h0,4'h0,7'h00,8'h5A,8'hC3,8'h00,1'b1,4'd7},  // R7
    '{1'b0,1'b1,5'h16,4'h0,4'h0,4'h0,4'h0,7'h00,8'h5A,8'hC3,8'h5A,1'b0,4'd8},  // R8
    '{1'b0,1'b1,5'h17,4'h0,4'h0,4'h0,4'h0,7'h00,8'h5A,8'hC3,8'hC3,1'b0,4'd8},  // R8
    '{1'b0,1'b1,5'h15,4'h0,4'h0,4'h0,4'h0,7'h00,8'h5A,8'hC3,8'h00,1'b1,4'd8},  // R8
    '{1'b0,1'b1,5'h18,4'h3,4'hA,4'h0,4'h0,7'h00,8'h00,8'h00,8'h00,1'b0,4'd9},  // R9
    '{1'b0,1'b1,5'h1A,4'h0,4'h0,4'h0,4'h0,7'h7F,8'h00,8'h00,8'h00,1'b0,4'd9},  // R9
    '{1'b1,1'b0,5'h18,4'h3,4'hA,4'h0,4'h0,7'h00,8'h00,8'h00,8'h00,1'b0,4'd10}, // R10
    '{1'b1,1'b1,5'h1F,4'h3,4'hA,4'h5,4'hC,7'h7F,8'h5A,8'hC3,8'h00,1'b1,4'd7}   // R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // write on the next edge, then sample just after it
  task automatic do_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 freeze", freeze_o, 0);
    check("R1 load", seq_load_o, 0);
    check("R1 step", seq_step_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 freeze after release", freeze_o, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      test_en_i = VECS[i].test; rd_i = VECS[i].rd; addr_i = VECS[i].addr;
      pulse_a_dac_i = VECS[i].pa; pulse_b_dac_i = VECS[i].pb;
      tri_dac_i = VECS[i].tr; noise_dac_i = VECS[i].nz; dmc_dac_i = VECS[i].dmc;
      pad0_i = VECS[i].p0; pad1_i = VECS[i].p1;
      #1;
      check($sformatf("R%0d vec %0d data", VECS[i].req, i), rdata_o, VECS[i].exp_data);
      check($sformatf("R%0d vec %0d cut", VECS[i].req, i), bus_cut_o, VECS[i].exp_cut);
    end
    @(negedge clk_i);
    rd_i = 1'b0; test_en_i = 1'b1;

    // R5 R6: load step 0x1F with freeze set
    do_write(5'h1A, 8'h9F);
    check("R5 load pulse", seq_load_o, 1);
    check("R5 step", seq_step_o, 5'h1F);
    check("R6 freeze set", freeze_o, 1);
    @(posedge clk_i); #1;
    check("R5 single pulse", seq_load_o, 0);
    check("R5 step held", seq_step_o, 5'h1F);
    check("R6 freeze held", freeze_o, 1);

    // R5: bits 6:5 ignored, bit7 clear
    do_write(5'h1A, 8'h75);
    check("R5 step ignores 6:5", seq_step_o, 5'h15);
    check("R6 freeze cleared", freeze_o, 0);

    // R5: other offset gives no strobe
    do_write(5'h19, 8'h83);
    check("R5 no load other offset", seq_load_o, 0);
    check("R5 step kept", seq_step_o, 5'h15);
    check("R6 freeze unaffected", freeze_o, 0);

    do_write(5'h1A, 8'hE3);
    check("R6 freeze set again", freeze_o, 1);
    check("R5 step 3", seq_step_o, 5'h03);

    // R6: leaving test mode drops freeze at once
    @(negedge clk_i);
    test_en_i = 1'b0;
    #1;
    check("R6 freeze off with test low", freeze_o, 0);

    // R9: write with test mode off is ignored
    do_write(5'h1A, 8'h9C);
    check("R9 no load", seq_load_o, 0);
    check("R9 step unchanged", seq_step_o, 5'h03);
    check("R9 freeze unchanged", freeze_o, 0);

    // R6: stored bit cleared on return to test mode
    @(negedge clk_i);
    test_en_i = 1'b1;
    #1;
    check("R6 freeze clear on reentry", freeze_o, 0);

    // R1: asynchronous reset clears a loaded state
    do_write(5'h1A, 8'h8A);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 reset freeze", freeze_o, 0);
    check("R1 reset step", seq_step_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule